// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Mask and Pending Controller

This block keeps the mask and pending state for every vector of a message-signalled interrupt function with a small vector table. Software reaches it through two write paths. The first is the capability control word, whose only writable bits are the function enable and the function-wide mask-all. The second is a per-vector control write, which sets or clears that vector's own mask bit. Event sources raise one request line per vector. The block answers with a one-cycle message-send strobe that carries the index of the vector to deliver. Message address and data storage, configuration-space decoding and bus transactions all belong to the surrounding logic.

A vector is masked when its own mask bit is set or when mask-all is set. A request on a deliverable vector is sent on the next clock edge. A request on a masked vector, or any request while the function is disabled, is held in that vector's pending bit. Whenever pending vectors become deliverable, for any of these reasons, they are sent one per clock, lowest index first, and a busy flag stays high until none remain:
- a vector is unmasked,
- mask-all is cleared,
- the function is enabled.

Each accepted control write that leaves the function enabled also produces a one-cycle pulse that tells the legacy interrupt line to deassert.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset, `ctl_word` reads enable=0 (bit 15), mask-all=0 (bit 14), bits 13:11 zero and bits 10:0 = NUM_VEC-1. In the same state every bit of `vec_mask` is 1, `pend_bits` is 0, and `msg_valid`, `busy` and `intx_deassert` are 0.
- R2: A control write (`ctl_wr_en`=1) loads enable from `ctl_wr_fn_en` into bit 15 and mask-all from `ctl_wr_fn_mask` into bit 14 of `ctl_word`, visible after the edge. Bits 13:0 never change.
- R3: A vector is masked when mask-all is 1 or its `vec_mask` bit is 1. A request on a masked vector, or any request while enable is 0, sets that vector's pending bit and sends no message.
- R4: A request on vector v that is deliverable, with no lower-index vector deliverable in the same cycle, gives `msg_valid`=1 and `msg_vec`=v one cycle later, and v's pending bit stays 0.
- R5: A vector control write (`vc_wr_en`=1) copies `vc_wr_mask` into `vec_mask[vc_wr_idx]` only. An index of NUM_VEC or above changes nothing.
- R6: When a pending vector becomes deliverable, it is sent, and its pending bit clears on the same edge that raises `msg_valid`.
- R7: `busy` is 1 exactly when the function is enabled and some pending vector is deliverable.
- R8: At most one message leaves per clock. When several vectors are deliverable, the lowest index goes first and the others stay pending.
- R9: `intx_deassert` pulses for one cycle, one cycle after a control write with `ctl_wr_fn_en`=1. It stays 0 otherwise.
- R10: `pend_bits[v]` is the pending bit of vector v. Read as bytes, vector v sits at bit v mod 8 of byte v div 8.
- R11: A request that arrives while earlier pending vectors are still being drained follows the same rules and is never lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_en | input | 1 | Control-word write strobe |
| ctl_wr_fn_en | input | 1 | Enable value for the control write |
| ctl_wr_fn_mask | input | 1 | Mask-all value for the control write |
| ctl_word | output | 16 | Control word readback |
| intx_deassert | output | 1 | One-cycle legacy line deassert pulse |
| vc_wr_en | input | 1 | Vector control write strobe |
| vc_wr_idx | input | IW | Vector index of the write |
| vc_wr_mask | input | 1 | New mask bit for that vector |
| vec_mask | output | NUM_VEC | Per-vector mask bits |
| pend_bits | output | NUM_VEC | Per-vector pending bits |
| evt_req | input | NUM_VEC | Per-vector event requests |
| msg_valid | output | 1 | Message-send strobe |
| msg_vec | output | IW | Vector index of the message |
| busy | output | 1 | Deliverable pending vectors remain |

## Verification
The directed patterns each isolate one rule:
- Requests made while disabled show that the enable gate holds events back.
- Requests made under mask-all show that the function-wide mask holds them back.
- Clearing mask-all over several pending vectors shows the drain order and the busy flag.
- Injecting a low-index request in the middle of that drain shows that priority beats arrival order.
- Masking and unmasking a single vector separates the per-vector mask path from the function-wide one.
- Writes to out-of-range indices show that they are ignored.

Long seeded random traffic then mixes sparse requests, mask writes and control writes. Every output is compared each cycle with a bench reference model, which catches priority, pending-loss and gating faults that the directed cases miss.

// File: rtl/msix_vc_pkg.sv
// Shared types and bit positions for the vector mask/pending controller.
// Assumes a 16-bit control word with enable and mask-all in its upper byte.
package msix_vc_pkg;
    localparam int CTL_EN_BIT   = 15;
    localparam int CTL_MASK_BIT = 14;
    localparam int CTL_SIZE_W   = 11;

    typedef struct packed {
        logic fn_en;
        logic fn_mask;
    } fn_ctl_t;
endpackage

// File: rtl/msix_ctl_reg.sv
// Function control register: holds enable and mask-all, forms the readback
// word and the legacy-line deassert pulse.
// Assumes the configuration decoder has already extracted the two writable bits.
module msix_ctl_reg
    import msix_vc_pkg::*;
#(
    parameter int NUM_VEC = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_fn_en,
    input  logic        wr_fn_mask,
    output fn_ctl_t     ctl,
    output logic [15:0] ctl_word,
    output logic        intx_clr
);
    localparam logic [CTL_SIZE_W-1:0] SIZE_FIELD = CTL_SIZE_W'(NUM_VEC - 1);

    // Control bits and deassert pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl      <= '0;
            intx_clr <= 1'b0;
        end else begin
            if (wr_en) begin
                ctl.fn_en   <= wr_fn_en;
                ctl.fn_mask <= wr_fn_mask;
            end
            intx_clr <= wr_en && wr_fn_en;
        end
    end

    // Readback word with the fixed table-size field.
    always_comb begin
        ctl_word                 = '0;
        ctl_word[CTL_EN_BIT]     = ctl.fn_en;
        ctl_word[CTL_MASK_BIT]   = ctl.fn_mask;
        ctl_word[CTL_SIZE_W-1:0] = SIZE_FIELD;
    end

    assert_intx_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        intx_clr |-> $past(wr_en && wr_fn_en));

    assert_ctl_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en)) |-> (ctl == $past(ctl)));
endmodule

// File: rtl/msix_vec_state.sv
// Per-vector mask and pending bits. Mask bits come from the vector control
// port; pending bits collect requests and clear when their vector is granted.
// Assumes grant is one-hot or zero and only covers requested or pending vectors.
module msix_vec_state #(
    parameter int NUM_VEC = 8,
    parameter int IW      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vc_wr_en,
    input  logic [IW-1:0]      vc_wr_idx,
    input  logic               vc_wr_mask,
    input  logic [NUM_VEC-1:0] evt,
    input  logic [NUM_VEC-1:0] grant,
    output logic [NUM_VEC-1:0] vmask,
    output logic [NUM_VEC-1:0] pend
);
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        // Mask bit: set on reset, written by the per-vector control port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                vmask[v] <= 1'b1;
            else if (vc_wr_en && (vc_wr_idx == IW'(v)))
                vmask[v] <= vc_wr_mask;
        end

        // Pending bit: accumulates requests, cleared by a grant.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[v] <= 1'b0;
            else
                pend[v] <= (pend[v] | evt[v]) & ~grant[v];
        end

        assert_event_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(evt[v]) && !$past(grant[v])) |-> pend[v]);

        assert_grant_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(grant[v])) |-> !pend[v]);
    end
endmodule

// File: rtl/msix_pick.sv
// Lowest-index picker: isolates the lowest set candidate bit and encodes it.
// Assumes NUM_VEC fits in IW bits.
module msix_pick #(
    parameter int NUM_VEC = 8,
    parameter int IW      = 3
) (
    input  logic [NUM_VEC-1:0] cand,
    output logic [NUM_VEC-1:0] grant,
    output logic [IW-1:0]      idx,
    output logic               any
);
    // Two's-complement trick isolates the lowest set bit.
    always_comb begin
        grant = cand & (~cand + NUM_VEC'(1));
        any   = |cand;
    end

    // Encode the one-hot grant into an index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (grant[i]) idx = IW'(i);
        end
    end

    always_comb begin
        assert_single_grant_R8: assert ($onehot0(grant));
        assert_grant_in_cand_R8: assert ((grant & ~cand) == '0);
    end
endmodule

// File: rtl/msix_vec_ctrl.sv
// Top of the vector mask/pending controller. Combines the function control,
// per-vector state and lowest-index picker; registers one message per clock.
// Assumes requests are single-cycle strobes per event.
module msix_vec_ctrl
    import msix_vc_pkg::*;
#(
    parameter int NUM_VEC = 8,
    localparam int IW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr_en,
    input  logic               ctl_wr_fn_en,
    input  logic               ctl_wr_fn_mask,
    output logic [15:0]        ctl_word,
    output logic               intx_deassert,
    input  logic               vc_wr_en,
    input  logic [IW-1:0]      vc_wr_idx,
    input  logic               vc_wr_mask,
    output logic [NUM_VEC-1:0] vec_mask,
    output logic [NUM_VEC-1:0] pend_bits,
    input  logic [NUM_VEC-1:0] evt_req,
    output logic               msg_valid,
    output logic [IW-1:0]      msg_vec,
    output logic               busy
);
    fn_ctl_t            ctl;
    logic [NUM_VEC-1:0] eff_mask;
    logic [NUM_VEC-1:0] cand;
    logic [NUM_VEC-1:0] grant;
    logic [IW-1:0]      pick_idx;
    logic               pick_any;

    msix_ctl_reg #(.NUM_VEC(NUM_VEC)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctl_wr_en),
        .wr_fn_en   (ctl_wr_fn_en),
        .wr_fn_mask (ctl_wr_fn_mask),
        .ctl        (ctl),
        .ctl_word   (ctl_word),
        .intx_clr   (intx_deassert)
    );

    msix_vec_state #(.NUM_VEC(NUM_VEC), .IW(IW)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .vc_wr_en   (vc_wr_en),
        .vc_wr_idx  (vc_wr_idx),
        .vc_wr_mask (vc_wr_mask),
        .evt        (evt_req),
        .grant      (grant),
        .vmask      (vec_mask),
        .pend       (pend_bits)
    );

    // Deliverable set: pending or newly requested, unmasked, function enabled.
    always_comb begin
        eff_mask = vec_mask | {NUM_VEC{ctl.fn_mask}};
        cand     = ctl.fn_en ? ((pend_bits | evt_req) & ~eff_mask) : '0;
        busy     = ctl.fn_en && |(pend_bits & ~eff_mask);
    end

    msix_pick #(.NUM_VEC(NUM_VEC), .IW(IW)) u_pick (
        .cand  (cand),
        .grant (grant),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    // Message register: one vector index per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_vec   <= '0;
        end else begin
            msg_valid <= pick_any;
            msg_vec   <= pick_idx;
        end
    end

    assert_sent_only_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> $past(ctl.fn_en));

    assert_sent_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (($past(eff_mask) >> msg_vec) & NUM_VEC'(1)) == '0);

    assert_sent_not_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (((pend_bits >> msg_vec) & NUM_VEC'(1)) == '0));
endmodule

// File: tb/msix_vec_ctrl_tb.sv
`timescale 1ns/1ps
module msix_vec_ctrl_tb;
    localparam int N  = 6;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr_en = 0, ctl_wr_fn_en = 0, ctl_wr_fn_mask = 0;
    logic [15:0]   ctl_word;
    logic          intx_deassert;
    logic          vc_wr_en = 0, vc_wr_mask = 0;
    logic [IW-1:0] vc_wr_idx = '0;
    logic [N-1:0]  vec_mask, pend_bits;
    logic [N-1:0]  evt_req = '0;
    logic          msg_valid, busy;
    logic [IW-1:0] msg_vec;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    logic         m_en, m_ma, e_valid, e_intx;
    logic [N-1:0] m_vmask, m_pend;
    logic [IW-1:0] e_vec;

    always #4 clk = ~clk;

    msix_vec_ctrl #(.NUM_VEC(N)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_fn_en(ctl_wr_fn_en), .ctl_wr_fn_mask(ctl_wr_fn_mask),
        .ctl_word(ctl_word), .intx_deassert(intx_deassert),
        .vc_wr_en(vc_wr_en), .vc_wr_idx(vc_wr_idx), .vc_wr_mask(vc_wr_mask),
        .vec_mask(vec_mask), .pend_bits(pend_bits), .evt_req(evt_req),
        .msg_valid(msg_valid), .msg_vec(msg_vec), .busy(busy)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(logic en, logic ma);
        return {en, ma, 3'b000, 11'(N - 1)};
    endfunction

    function automatic logic exp_busy();
        logic [N-1:0] eff = m_ma ? {N{1'b1}} : m_vmask;
        return m_en && |(m_pend & ~eff);
    endfunction

    // One clock: drive inputs, advance the model, compare every output.
    task automatic step(input logic ce, input logic cen, input logic cma,
                        input logic ve, input logic [IW-1:0] vi, input logic vm,
                        input logic [N-1:0] ev, input string tag);
        logic [N-1:0] eff, cand;
        @(negedge clk);
        ctl_wr_en = ce; ctl_wr_fn_en = cen; ctl_wr_fn_mask = cma;
        vc_wr_en = ve; vc_wr_idx = vi; vc_wr_mask = vm; evt_req = ev;
        eff  = m_ma ? {N{1'b1}} : m_vmask;
        cand = m_en ? ((m_pend | ev) & ~eff) : '0;
        e_valid = 1'b0;
        e_vec   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                e_valid = 1'b1;
                e_vec   = IW'(i);
            end
        end
        m_pend = m_pend | ev;
        if (e_valid) m_pend[e_vec] = 1'b0;
        if (ve && int'(vi) < N) m_vmask[vi] = vm;
        e_intx = ce && cen;
        if (ce) begin
            m_en = cen;
            m_ma = cma;
        end
        @(posedge clk);
        #1;
        chk({tag, "/R8"}, "msg_valid", 32'(msg_valid), 32'(e_valid));
        if (e_valid) chk({tag, "/R4"}, "msg_vec", 32'(msg_vec), 32'(e_vec));
        chk({tag, "/R10"}, "pend_bits", 32'(pend_bits), 32'(m_pend));
        chk({tag, "/R5"}, "vec_mask", 32'(vec_mask), 32'(m_vmask));
        chk({tag, "/R2"}, "ctl_word", 32'(ctl_word), 32'(exp_word(m_en, m_ma)));
        chk({tag, "/R9"}, "intx_deassert", 32'(intx_deassert), 32'(e_intx));
        chk({tag, "/R7"}, "busy", 32'(busy), 32'(exp_busy()));
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, '0, 0, '0, tag);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_en = 0; m_ma = 0; m_vmask = '1; m_pend = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "ctl_word", 32'(ctl_word), 32'h0005);
        chk("R1", "vec_mask", 32'(vec_mask), 32'h3F);
        chk("R1", "pend_bits", 32'(pend_bits), 0);
        chk("R1", "msg_valid", 32'(msg_valid), 0);
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "intx_deassert", 32'(intx_deassert), 0);

        // R3: request while disabled is held
        step(0, 0, 0, 0, '0, 0, 6'b000100, "R3");
        // R2/R9: enable with mask-all set
        step(1, 1, 1, 0, '0, 0, '0, "R2");
        // R5: unmask every vector; out-of-range indices ignored
        for (int v = 0; v < N; v++) step(0, 0, 0, 1, IW'(v), 0, '0, "R5");
        step(0, 0, 0, 1, 3'd6, 1, '0, "R5");
        step(0, 0, 0, 1, 3'd7, 1, '0, "R5");
        // R3: requests under mask-all are held
        step(0, 0, 0, 0, '0, 0, 6'b110001, "R3");
        chk("R3", "pend_bits", 32'(pend_bits), 32'h35);
        // R7: clear mask-all, drain ascending; R11: inject vector 1 mid-drain
        step(1, 1, 0, 0, '0, 0, '0, "R7");
        chk("R7", "busy", 32'(busy), 1);
        step(0, 0, 0, 0, '0, 0, '0, "R7");
        chk("R8", "first drained", 32'(msg_vec), 0);
        step(0, 0, 0, 0, '0, 0, 6'b000010, "R11");
        chk("R11", "injected lower index", 32'(msg_vec), 1);
        idle(4, "R7");
        chk("R7", "busy after drain", 32'(busy), 0);
        // R6: mask vector 3, request, then unmask
        step(0, 0, 0, 1, 3'd3, 1, '0, "R6");
        step(0, 0, 0, 0, '0, 0, 6'b001000, "R6");
        step(0, 0, 0, 1, 3'd3, 0, '0, "R6");
        step(0, 0, 0, 0, '0, 0, '0, "R6");
        chk("R6", "unmasked delivery", 32'(msg_vec), 3);
        // R4: immediate send
        step(0, 0, 0, 0, '0, 0, 6'b100000, "R4");
        // R9: disabling write gives no pulse; R3: held while disabled
        step(1, 0, 0, 0, '0, 0, '0, "R9");
        step(0, 0, 0, 0, '0, 0, 6'b101010, "R3");
        step(1, 1, 0, 0, '0, 0, '0, "R9");
        idle(4, "R8");
        // Constrained random traffic
        for (int k = 0; k < 3000; k++) begin
            logic ce, cen, cma, ve, vm;
            logic [IW-1:0] vi;
            logic [N-1:0] ev;
            ce  = ($urandom % 40) == 0;
            cen = ($urandom % 4) != 0;
            cma = ($urandom % 3) == 0;
            ve  = ($urandom % 8) == 0;
            vi  = IW'($urandom);
            vm  = ($urandom % 3) == 0;
            ev  = N'($urandom & $urandom & $urandom);
            step(ce, cen, cma, ve, vi, vm, ev, "RND");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule